// File: doc/BRIEF.md
# Streaming Patch Image Validator

The validator inspects a firmware-patch image while it streams past as 32-bit words on a valid/ready input. It keeps only what it needs: a few header fields, two running modulo-2^32 sums, and a small amount of state for the optional extended-signature table that may follow the payload. It never stores the image. When the word flagged as last is accepted, the block reports one verdict code for the whole image. Code zero means the image is acceptable.

The header is twelve words long. The block decodes the fields it needs by word position:

- word 0: header type
- word 3: signature
- word 4: checksum
- word 5: loader version
- word 6: platform flags
- word 7: data size, in bytes
- word 8: total size, in bytes

The payload follows the header. Any bytes between the end of the payload and the total size form the extended table. That table starts with five words: entry count at table word 0, table checksum at table word 1, and three spare words. Entries of three words follow: signature, flags, checksum.

An upstream loader streams each image into the block and reads the code from the result cycle. The expected header type comes from a port and must be held stable while an image is in flight.

Top module: `patch_img_validator`

## Requirements
- R1: `in_ready` is high whenever no result is being shown. The cycle after the word with `in_last` is accepted, `res_valid` is high for exactly one cycle, and `in_ready` is low in that cycle. No word is accepted then.
- R2: If the data-size word (word 7) is zero, the payload is taken as DEF_DATA_BYTES (default 2000) and the total as that plus 48. The total-size word is then ignored. Otherwise the total comes from word 8.
- R3: Code 1 (length) is reported when fewer than 12 words arrive, when the total is not a multiple of 4, or when the number of words differs from total/4.
- R4: Code 2 (size) is reported when 48 plus the payload size exceeds the total.
- R5: Code 3 (version) is reported when word 5 is not 1, or when word 0 differs from `exp_hdr_type`.
- R6: When an extended region exists (total minus 48 minus payload is non-zero), code 4 (truncated) is reported if that region is under 20 bytes, or if its size minus 20 is not a multiple of 12.
- R7: Code 5 (table size) is reported when the extended region size differs from count×12+20.
- R8: Code 6 (table sum) is reported when the modulo-2^32 sum of all extended-region words is non-zero.
- R9: Code 7 (main sum) is reported when the modulo-2^32 sum of all header and payload words is non-zero.
- R10: Code 8 (entry) is reported when, for any of the first `count` entries, the sum (word 3 + word 4 + word 6) minus the sum of the entry's three words is non-zero.
- R11: When several faults are present, the lowest non-zero code among them is reported. Code 0 is reported only when no fault is present, and no code above 8 ever appears.
- R12: All state is cleared after the result cycle, so the verdict for an image does not depend on the images before it.
- R13: Cycles with `in_valid` low are ignored, including their `in_data` and `in_last` values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input word is valid |
| in_ready | output | 1 | Block can accept a word |
| in_data | input | 32 | Image word |
| in_last | input | 1 | Marks the final word of the image |
| exp_hdr_type | input | 32 | Header type the image must carry |
| res_valid | output | 1 | One-cycle verdict strobe |
| res_code | output | 4 | Verdict code (0 means pass), valid with res_valid |

## Verification
On every cycle the assertions check the handshake timing:

- a result appears only right after an accepted last word;
- it lasts one cycle;
- its code stays in range;
- an image shorter than the header always yields the length code.

The checks on header decoding, the size arithmetic, the three sums and the priority between faults need complete images built with specific faults. So they are shown only by the bench's scenarios, each compared against a behavioural reference.

// File: rtl/piv_pkg.sv
package piv_pkg;

    localparam int DW           = 32;
    localparam int HDR_WORDS    = 12;
    localparam int HDR_BYTES    = HDR_WORDS * 4;
    localparam int TBL_HDR_WRDS = 5;
    localparam int TBL_HDR_BYTS = TBL_HDR_WRDS * 4;
    localparam int ENT_WORDS    = 3;
    localparam int ENT_BYTES    = ENT_WORDS * 4;
    localparam int GW           = 34;   // geometry arithmetic width
    localparam int MW           = 36;   // table size product width

    // header word positions decoded by the block
    localparam int POS_TYPE  = 0;
    localparam int POS_SIG   = 3;
    localparam int POS_CKSUM = 4;
    localparam int POS_LDR   = 5;
    localparam int POS_FLAGS = 6;
    localparam int POS_DSIZE = 7;
    localparam int POS_TSIZE = 8;

    localparam logic [DW-1:0] LDR_OK = 32'd1;

    typedef enum logic [3:0] {
        V_PASS      = 4'd0,
        V_LENGTH    = 4'd1,
        V_SIZE      = 4'd2,
        V_VERSION   = 4'd3,
        V_TRUNC     = 4'd4,
        V_TBL_SIZE  = 4'd5,
        V_TBL_SUM   = 4'd6,
        V_MAIN_SUM  = 4'd7,
        V_ENTRY     = 4'd8
    } verdict_e;

    typedef struct packed {
        logic [DW-1:0] hdr_type;
        logic [DW-1:0] ldr_ver;
        logic [DW-1:0] dsize;
        logic [DW-1:0] tsize;
        logic [DW-1:0] triple;
    } hdr_t;

    typedef struct packed {
        logic [GW-1:0] main_bytes;
        logic [GW-1:0] total_bytes;
        logic [GW-1:0] tbl_bytes;
        logic          size_bad;
    } geom_t;

    typedef struct packed {
        logic [DW-1:0] main_sum;
        logic [DW-1:0] tbl_sum;
        logic [DW-1:0] tbl_count;
        logic          entry_bad;
    } sums_t;

    function automatic geom_t calc_geom(hdr_t h, logic [GW-1:0] def_data);
        geom_t         g;
        logic [GW-1:0] data_b;
        data_b        = (h.dsize == '0) ? def_data : GW'(h.dsize);
        g.total_bytes = (h.dsize == '0) ? def_data + GW'(HDR_BYTES) : GW'(h.tsize);
        g.main_bytes  = data_b + GW'(HDR_BYTES);
        g.size_bad    = g.main_bytes > g.total_bytes;
        g.tbl_bytes   = g.total_bytes - g.main_bytes;
        return g;
    endfunction

endpackage

// File: rtl/piv_hdr_capture.sv
module piv_hdr_capture
    import piv_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             acc,
    input  logic [CNT_W-1:0] idx,
    input  logic [DW-1:0]    word,
    output hdr_t             hdr
);
    hdr_t hdr_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            hdr_q <= '0;
        end else if (acc) begin
            if (idx == CNT_W'(POS_TYPE))  hdr_q.hdr_type <= word;
            if (idx == CNT_W'(POS_LDR))   hdr_q.ldr_ver  <= word;
            if (idx == CNT_W'(POS_DSIZE)) hdr_q.dsize    <= word;
            if (idx == CNT_W'(POS_TSIZE)) hdr_q.tsize    <= word;
            if (idx == CNT_W'(POS_SIG) || idx == CNT_W'(POS_CKSUM) ||
                idx == CNT_W'(POS_FLAGS))
                hdr_q.triple <= hdr_q.triple + word;
        end
    end

    assign hdr = hdr_q;
endmodule

// File: rtl/piv_region_sums.sv
module piv_region_sums
    import piv_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             acc,
    input  logic [CNT_W-1:0] idx,
    input  logic [DW-1:0]    word,
    input  logic [GW-1:0]    main_words,
    input  logic [DW-1:0]    triple,
    output sums_t            sums
);
    localparam int POS_W = $clog2(TBL_HDR_WRDS + 1);
    localparam int FLD_W = $clog2(ENT_WORDS);

    sums_t            s_q;
    logic [POS_W-1:0] tbl_pos_q;
    logic [FLD_W-1:0] fld_q;
    logic [DW-1:0]    part_q;
    logic [DW-1:0]    ent_idx_q;
    logic             in_main;
    logic [DW-1:0]    ent_total;

    assign in_main   = (idx < CNT_W'(HDR_WORDS)) || (GW'(idx) < main_words);
    assign ent_total = part_q + word;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            s_q       <= '0;
            tbl_pos_q <= '0;
            fld_q     <= '0;
            part_q    <= '0;
            ent_idx_q <= '0;
        end else if (acc) begin
            if (in_main) begin
                s_q.main_sum <= s_q.main_sum + word;
            end else begin
                s_q.tbl_sum <= s_q.tbl_sum + word;
                if (tbl_pos_q == '0)
                    s_q.tbl_count <= word;
                if (tbl_pos_q < POS_W'(TBL_HDR_WRDS)) begin
                    tbl_pos_q <= tbl_pos_q + 1'b1;
                end else if (fld_q == FLD_W'(ENT_WORDS - 1)) begin
                    fld_q     <= '0;
                    part_q    <= '0;
                    ent_idx_q <= ent_idx_q + 1'b1;
                    if (ent_idx_q < s_q.tbl_count && (triple - ent_total) != '0)
                        s_q.entry_bad <= 1'b1;
                end else begin
                    fld_q  <= fld_q + 1'b1;
                    part_q <= ent_total;
                end
            end
        end
    end

    assign sums = s_q;
endmodule

// File: rtl/piv_verdict.sv
module piv_verdict
    import piv_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic [CNT_W-1:0] n_words,
    input  hdr_t             hdr,
    input  geom_t            geom,
    input  sums_t            sums,
    input  logic [DW-1:0]    exp_type,
    output verdict_e         verdict
);
    logic len_bad, ver_bad, has_tbl, trunc_bad, tsz_bad;

    always_comb begin
        len_bad   = (n_words < CNT_W'(HDR_WORDS)) || (geom.total_bytes[1:0] != 2'b00) ||
                    (GW'(n_words) != (geom.total_bytes >> 2));
        ver_bad   = (hdr.ldr_ver != LDR_OK) || (hdr.hdr_type != exp_type);
        has_tbl   = geom.tbl_bytes != '0;
        trunc_bad = has_tbl && ((geom.tbl_bytes < GW'(TBL_HDR_BYTS)) ||
                    (((geom.tbl_bytes - GW'(TBL_HDR_BYTS)) % GW'(ENT_BYTES)) != '0));
        tsz_bad   = has_tbl && (MW'(geom.tbl_bytes) !=
                    MW'(sums.tbl_count) * MW'(ENT_BYTES) + MW'(TBL_HDR_BYTS));

        if (len_bad)                             verdict = V_LENGTH;
        else if (geom.size_bad)                  verdict = V_SIZE;
        else if (ver_bad)                        verdict = V_VERSION;
        else if (trunc_bad)                      verdict = V_TRUNC;
        else if (tsz_bad)                        verdict = V_TBL_SIZE;
        else if (has_tbl && sums.tbl_sum != '0)  verdict = V_TBL_SUM;
        else if (sums.main_sum != '0)            verdict = V_MAIN_SUM;
        else if (has_tbl && sums.entry_bad)      verdict = V_ENTRY;
        else                                     verdict = V_PASS;
    end
endmodule

// File: rtl/patch_img_validator.sv
module patch_img_validator
    import piv_pkg::*;
#(
    parameter int CNT_W          = 32,
    parameter int DEF_DATA_BYTES = 2000
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [31:0]   in_data,
    input  logic          in_last,
    input  logic [31:0]   exp_hdr_type,
    output logic          res_valid,
    output logic [3:0]    res_code
);
    localparam logic [GW-1:0] DEF_DATA = GW'(DEF_DATA_BYTES);

    logic [CNT_W-1:0] n_q;
    logic             res_q;
    logic             acc;
    hdr_t             hdr;
    geom_t            geom;
    sums_t            sums;
    verdict_e         verdict;

    assign acc = in_valid && !res_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            n_q   <= '0;
            res_q <= 1'b0;
        end else if (res_q) begin
            n_q   <= '0;
            res_q <= 1'b0;
        end else if (acc) begin
            n_q <= n_q + 1'b1;
            if (in_last)
                res_q <= 1'b1;
        end
    end

    piv_hdr_capture #(.CNT_W(CNT_W)) u_hdr (
        .clk (clk), .rst (rst), .clr (res_q), .acc (acc),
        .idx (n_q), .word (in_data), .hdr (hdr)
    );

    assign geom = calc_geom(hdr, DEF_DATA);

    piv_region_sums #(.CNT_W(CNT_W)) u_sums (
        .clk (clk), .rst (rst), .clr (res_q), .acc (acc),
        .idx (n_q), .word (in_data),
        .main_words (geom.main_bytes >> 2),
        .triple (hdr.triple), .sums (sums)
    );

    piv_verdict #(.CNT_W(CNT_W)) u_verdict (
        .n_words (n_q), .hdr (hdr), .geom (geom), .sums (sums),
        .exp_type (exp_hdr_type), .verdict (verdict)
    );

    assign in_ready  = !res_q;
    assign res_valid = res_q;
    assign res_code  = res_q ? verdict : V_PASS;
endmodule

// File: rtl/piv_checker.sv
module piv_checker (
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic        in_ready,
    input logic        in_last,
    input logic        res_valid,
    input logic [3:0]  res_code
);
    logic        acc_last;
    logic [31:0] seen_q;

    assign acc_last = in_valid && in_ready && in_last;

    always_ff @(posedge clk) begin
        if (rst || res_valid)            seen_q <= '0;
        else if (in_valid && in_ready)   seen_q <= seen_q + 1'b1;
    end

    AST_RESULT_FOLLOWS_LAST: assert property (@(posedge clk) disable iff (rst)
        acc_last |=> res_valid);  // R1
    AST_RESULT_SINGLE: assert property (@(posedge clk) disable iff (rst)
        res_valid |=> !res_valid);  // R1
    AST_NO_SPURIOUS_RESULT: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> $past(acc_last));  // R1
    AST_SHORT_IS_LENGTH: assert property (@(posedge clk) disable iff (rst)
        (acc_last && seen_q < 32'd11) |=> (res_code == 4'd1));  // R3
    AST_CODE_RANGE: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> (res_code <= 4'd8));  // R11
endmodule

bind patch_img_validator piv_checker u_chk (
    .clk (clk), .rst (rst), .in_valid (in_valid), .in_ready (in_ready),
    .in_last (in_last), .res_valid (res_valid), .res_code (res_code)
);

// File: tb/patch_img_validator_tb.sv
module patch_img_validator_tb;
    localparam logic [31:0] HT = 32'd1;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid, in_ready, in_last, res_valid;
    logic [31:0] in_data, exp_hdr_type;
    logic [3:0]  res_code;
    int          checks = 0, errors = 0, cyc = 0;

    always #4 clk = ~clk;

    patch_img_validator u_dut (
        .clk (clk), .rst (rst), .in_valid (in_valid), .in_ready (in_ready),
        .in_data (in_data), .in_last (in_last), .exp_hdr_type (exp_hdr_type),
        .res_valid (res_valid), .res_code (res_code)
    );

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++; checks++;
            $display("FAIL watchdog actual=%0d expected<=%0d", cyc, 150000);
            finish_run();
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // behavioural reference of the verdict
    function automatic int ref_code(input logic [31:0] q[$], input logic [31:0] ht);
        longint n, data_b, total, ext, mw;
        logic [31:0] s, tri_m, tri_e, cnt;
        n = q.size();
        if (n < 12) return 1;
        data_b = (q[7] == 0) ? 2000 : longint'(q[7]);
        total  = (q[7] == 0) ? 2048 : longint'(q[8]);
        if ((total % 4) != 0 || n != total / 4) return 1;
        if (48 + data_b > total) return 2;
        if (q[5] != 1 || q[0] != ht) return 3;
        ext = total - 48 - data_b;
        mw  = (48 + data_b) / 4;
        if (ext != 0) begin
            if (ext < 20 || ((ext - 20) % 12) != 0) return 4;
            cnt = q[mw];
            if (ext != longint'(cnt) * 12 + 20) return 5;
            s = 0;
            for (longint i = mw; i < n; i++) s += q[i];
            if (s != 0) return 6;
        end
        s = 0;
        for (longint i = 0; i < mw; i++) s += q[i];
        if (s != 0) return 7;
        if (ext != 0) begin
            tri_m = q[3] + q[4] + q[6];
            for (longint k = 0; k < longint'(q[mw]); k++) begin
                tri_e = q[mw+5+3*k] + q[mw+6+3*k] + q[mw+7+3*k];
                if (tri_m - tri_e != 0) return 8;
            end
        end
        return 0;
    endfunction

    function automatic void fix_main(ref logic [31:0] q[$]);
        int mw;
        logic [31:0] s;
        mw = ((q[7] == 0) ? 2048 : 48 + int'(q[7])) / 4;
        q[4] = 0; s = 0;
        for (int i = 0; i < mw; i++) s += q[i];
        q[4] = -s;
    endfunction

    function automatic void build(ref logic [31:0] q[$], input int ds, input int n_ent);
        int dwords;
        int base;
        logic [31:0] s, t, sg, pf;
        q.delete();
        dwords = (ds == 0) ? 500 : ds / 4;
        q.push_back(HT); q.push_back(32'h0000_0042); q.push_back(32'h0101_2024);
        q.push_back(32'h0009_06A3); q.push_back(32'h0); q.push_back(32'h1);
        q.push_back(32'h0000_0080); q.push_back(32'(ds));
        q.push_back((ds == 0) ? 32'h1234_5678 : 32'(48 + ds + ((n_ent > 0) ? 20 + 12 * n_ent : 0)));
        q.push_back(0); q.push_back(0); q.push_back(0);
        for (int i = 0; i < dwords; i++) q.push_back($urandom);
        fix_main(q);
        if (n_ent > 0) begin
            base = q.size();
            t = q[3] + q[4] + q[6];
            q.push_back(32'(n_ent)); q.push_back(0);
            q.push_back(0); q.push_back(0); q.push_back(0);
            for (int k = 0; k < n_ent; k++) begin
                sg = $urandom; pf = $urandom;
                q.push_back(sg); q.push_back(pf); q.push_back(t - sg - pf);
            end
            s = 0;
            for (int i = base; i < q.size(); i++) s += q[i];
            q[base+1] = -s;
        end
    endfunction

    task automatic run_img(input logic [31:0] q[$], input int gap_pct, input string req,
                           input int want);
        int exp, i;
        exp = ref_code(q, exp_hdr_type);
        chk(exp == want, {req, " reference"}, exp, want);
        i = 0;
        while (i < q.size()) begin
            @(negedge clk);
            chk(in_ready == 1'b1 && res_valid == 1'b0, {req, " R1 idle"},
                int'(res_valid), 0);
            if (gap_pct > 0 && ($urandom % 100) < gap_pct) begin
                in_valid = 1'b0; in_last = 1'b1; in_data = 32'hDEAD_BEEF;  // R13
            end else begin
                in_valid = 1'b1; in_data = q[i]; in_last = (i == q.size() - 1);
                i++;
            end
        end
        @(negedge clk);
        in_valid = 1'b0; in_last = 1'b0;
        chk(res_valid == 1'b1 && in_ready == 1'b0, {req, " R1 strobe"}, int'(res_valid), 1);
        chk(int'(res_code) == exp, req, int'(res_code), exp);
        @(negedge clk);
        chk(res_valid == 1'b0 && in_ready == 1'b1, {req, " R1 single"}, int'(res_valid), 0);
    endtask

    initial begin
        logic [31:0] q[$];
        int mw;
        rst = 1'b1; in_valid = 1'b0; in_last = 1'b0; in_data = '0; exp_hdr_type = HT;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        chk(in_ready == 1'b1 && res_valid == 1'b0 && res_code == 4'd0, "R1 reset",
            int'(res_valid), 0);

        build(q, 16, 0);  run_img(q, 0, "R11 pass plain", 0);
        build(q, 32, 2);  run_img(q, 0, "R10 pass with table", 0);
        build(q, 0, 0);   run_img(q, 0, "R2 default size", 0);
        build(q, 0, 0);   q.push_back(0);
        run_img(q, 0, "R2 default ignores total word", 1);
        build(q, 16, 0);  q = q[0:4];          run_img(q, 0, "R3 short", 1);
        build(q, 16, 0);  q.push_back(0);      run_img(q, 0, "R3 long", 1);
        build(q, 64, 0);  q[8] = 80; q = q[0:19];
        run_img(q, 0, "R4 size", 2);
        build(q, 16, 0);  q[0] = 32'd7; fix_main(q);
        run_img(q, 0, "R5 header type", 3);
        build(q, 16, 0);  q[5] = 32'd2;        run_img(q, 0, "R11 version before sum", 3);
        build(q, 16, 0);  q[8] = q[8] + 16;
        for (int k = 0; k < 4; k++) q.push_back(0);
        fix_main(q);      run_img(q, 0, "R6 truncated", 4);
        build(q, 16, 2);  mw = 16;
        q[mw] = 3;        run_img(q, 0, "R7 table size", 5);
        build(q, 16, 2);  q[mw+2] = q[mw+2] + 1;
        run_img(q, 0, "R8 table sum", 6);
        build(q, 16, 0);  q[12] = q[12] ^ 32'h1;
        run_img(q, 0, "R9 main sum", 7);
        build(q, 16, 2);  q[mw+5] = q[mw+5] + 1; q[mw+2] = q[mw+2] - 1;
        run_img(q, 0, "R10 entry", 8);
        build(q, 16, 2);  run_img(q, 0, "R12 pass after fail", 0);
        build(q, 40, 3);  run_img(q, 40, "R13 stalls", 0);

        finish_run();
    end
endmodule